// File: doc/BRIEF.md
# Fetch Address Watch List

This unit keeps a short, densely packed list of 16-bit program addresses and reports, in the same cycle, whether the address the processor is about to fetch is one of them. Debug logic uses the hit signal to stop execution before the watched instruction runs. The list is edited through a one-cycle command strobe carrying an address and one of four operations: add, remove, flip (remove if present, add otherwise) and wipe (empty the list).

Add, remove and flip first search the live entries one slot per cycle, and `busy` stays high while that search runs. New entries go to the slot indexed by the current count. A removed entry's slot is refilled with the entry at the tail, so the live entries always fill slots 0 to count-1 and their order is not kept. Wipe takes effect at once without a search.

Top module: `fetch_watch_unit`

## Requirements
- R1: After reset `entry_count` is 0, `busy` is 0 and `hit` is 0 for any fetch address.
- R2: An add (cmd_op 0) of an address not in the list, with fewer than ENTRIES entries live, stores it and raises `entry_count` by one; `hit` then goes high for that address.
- R3: An add or flip (cmd_op 2) of an absent address while ENTRIES entries are live changes nothing: the count stays at ENTRIES and the address does not hit.
- R4: An add of an address already in the list leaves `entry_count` and all hits unchanged.
- R5: A remove (cmd_op 1) of a listed address lowers `entry_count` by one; that address stops hitting and every other listed address still hits.
- R6: A remove of an address not in the list leaves `entry_count` and all hits unchanged.
- R7: A flip removes the address when it is listed and adds it otherwise, with the effects of R5 and R2.
- R8: A wipe (cmd_op 3) accepted while idle sets `entry_count` to 0 at the next clock edge and never raises `busy`.
- R9: `hit` is combinational from `fetch_addr` and is high only when the address equals one of the first `entry_count` slots; stale contents of slots at or above the count never hit.
- R10: A command is accepted only when `cmd_valid` is high and `busy` is low; a strobe while busy has no effect.
- R11: An accepted add, remove or flip keeps `busy` high for k+1 cycles when the address sits in slot k, and for count+1 cycles when it is absent; no list state changes while idle without a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | 0 add, 1 remove, 2 flip, 3 wipe |
| cmd_addr | input | 16 | Address the command refers to |
| busy | output | 1 | Search in progress; new commands ignored |
| entry_count | output | $clog2(ENTRIES+1) | Number of live entries |
| fetch_addr | input | 16 | Address being fetched |
| hit | output | 1 | fetch_addr is a live entry |

## Verification
The properties assume commands arrive as single-cycle strobes and that a strobe raised while `busy` is high is simply dropped, never held until the unit is free. The stimulus drives each strobe for one cycle while idle and then waits for `busy` to fall before the next one. The one exception is a deliberate strobe during a search, used to show that it is discarded. `fetch_addr` is moved only between edges, so each hit is sampled after the combinational compare has settled.

// File: rtl/fw_pkg.sv
package fw_pkg;
   typedef enum logic [1:0] {
      FW_ADD  = 2'd0,
      FW_DROP = 2'd1,
      FW_FLIP = 2'd2,
      FW_WIPE = 2'd3
   } fw_op_e;

   typedef enum logic {
      FW_IDLE = 1'b0,
      FW_SCAN = 1'b1
   } fw_state_e;
endpackage

// File: rtl/fw_entry_store.sv
module fw_entry_store #(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 16,
   parameter int IW      = 3,
   parameter int CW      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [IW-1:0]     rd_idx,
   output logic [ADDR_W-1:0] rd_data,
   input  logic [IW-1:0]     tail_idx,
   output logic [ADDR_W-1:0] tail_data,
   input  logic [CW-1:0]     live_count,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic [ENTRIES-1:0] hit_vec
);
   logic [ADDR_W-1:0] slot_q [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      localparam logic [CW-1:0] SLOT_NO = CW'(i);
      localparam logic [IW-1:0] SLOT_IX = IW'(i);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[i] <= '0;
         else if (wr_en && wr_idx == SLOT_IX)
            slot_q[i] <= wr_data;
      end

      assign hit_vec[i] = (SLOT_NO < live_count) && (slot_q[i] == fetch_addr);
   end

   assign rd_data   = slot_q[rd_idx];
   assign tail_data = slot_q[tail_idx];
endmodule

// File: rtl/fw_cmd_ctrl.sv
module fw_cmd_ctrl
   import fw_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 16,
   parameter int IW      = 3,
   parameter int CW      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [ADDR_W-1:0] rd_data,
   input  logic [ADDR_W-1:0] tail_data,
   output logic [IW-1:0]     rd_idx,
   output logic [IW-1:0]     tail_idx,
   output logic              wr_en,
   output logic [IW-1:0]     wr_idx,
   output logic [ADDR_W-1:0] wr_data,
   output logic [CW-1:0]     live_count,
   output logic              busy
);
   localparam logic [CW-1:0] FULL_COUNT = CW'(ENTRIES);

   fw_state_e         state_q;
   fw_op_e            op_q;
   fw_op_e            cmd_kind;
   logic [ADDR_W-1:0] addr_q;
   logic [CW-1:0]     idx_q;
   logic [CW-1:0]     count_q;
   logic [CW-1:0]     tail_sum;
   logic              at_end;
   logic              same;
   logic              full;
   logic              do_append;
   logic              do_remove;

   assign cmd_kind = fw_op_e'(cmd_op);
   assign at_end   = (idx_q >= count_q);
   assign same     = (rd_data == addr_q);
   assign full     = (count_q == FULL_COUNT);
   assign tail_sum = count_q - CW'(1);
   assign tail_idx = tail_sum[IW-1:0];
   assign rd_idx   = idx_q[IW-1:0];

   assign do_append = (state_q == FW_SCAN) && at_end && (op_q != FW_DROP) && !full;
   assign do_remove = (state_q == FW_SCAN) && !at_end && same && (op_q != FW_ADD);

   always_comb begin
      wr_en   = 1'b0;
      wr_idx  = idx_q[IW-1:0];
      wr_data = addr_q;
      if (do_append) begin
         wr_en   = 1'b1;
         wr_idx  = count_q[IW-1:0];
         wr_data = addr_q;
      end else if (do_remove) begin
         wr_en   = 1'b1;
         wr_idx  = idx_q[IW-1:0];
         wr_data = tail_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FW_IDLE;
         op_q    <= FW_ADD;
         addr_q  <= '0;
         idx_q   <= '0;
         count_q <= '0;
      end else begin
         case (state_q)
            FW_IDLE: begin
               if (cmd_valid) begin
                  if (cmd_kind == FW_WIPE) begin
                     count_q <= '0;
                  end else begin
                     state_q <= FW_SCAN;
                     op_q    <= cmd_kind;
                     addr_q  <= cmd_addr;
                     idx_q   <= '0;
                  end
               end
            end
            FW_SCAN: begin
               if (at_end) begin
                  if (do_append)
                     count_q <= count_q + CW'(1);
                  state_q <= FW_IDLE;
               end else if (same) begin
                  if (do_remove)
                     count_q <= tail_sum;
                  state_q <= FW_IDLE;
               end else begin
                  idx_q <= idx_q + CW'(1);
               end
            end
            default: state_q <= FW_IDLE;
         endcase
      end
   end

   assign live_count = count_q;
   assign busy       = (state_q == FW_SCAN);
endmodule

// File: rtl/fetch_watch_unit.sv
module fetch_watch_unit #(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 16,
   localparam int CW     = $clog2(ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic              busy,
   output logic [CW-1:0]     entry_count,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              hit
);
   localparam int IW = $clog2(ENTRIES);

   if (ENTRIES < 2 || ENTRIES > 256) begin : g_bad_entries
      $fatal(1, "fetch_watch_unit: ENTRIES must lie in 2..256");
   end
   if (ADDR_W < 1) begin : g_bad_width
      $fatal(1, "fetch_watch_unit: ADDR_W must be positive");
   end

   logic              wr_en;
   logic [IW-1:0]     wr_idx;
   logic [ADDR_W-1:0] wr_data;
   logic [IW-1:0]     rd_idx;
   logic [ADDR_W-1:0] rd_data;
   logic [IW-1:0]     tail_idx;
   logic [ADDR_W-1:0] tail_data;
   logic [CW-1:0]     live_count;
   logic [ENTRIES-1:0] hit_vec;

   fw_cmd_ctrl #(
      .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IW(IW), .CW(CW)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_addr   (cmd_addr),
      .rd_data    (rd_data),
      .tail_data  (tail_data),
      .rd_idx     (rd_idx),
      .tail_idx   (tail_idx),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .live_count (live_count),
      .busy       (busy)
   );

   fw_entry_store #(
      .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IW(IW), .CW(CW)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .rd_idx     (rd_idx),
      .rd_data    (rd_data),
      .tail_idx   (tail_idx),
      .tail_data  (tail_data),
      .live_count (live_count),
      .fetch_addr (fetch_addr),
      .hit_vec    (hit_vec)
   );

   assign entry_count = live_count;
   assign hit         = |hit_vec;
endmodule

// File: rtl/fw_watch_chk.sv
module fw_watch_chk #(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 16,
   localparam int CW     = $clog2(ENTRIES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              busy,
   input logic [CW-1:0]     entry_count,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              hit
);
   logic started;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   // R3
   count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_count <= CW'(ENTRIES));

   // R8
   wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_op == 2'd3) |=> (entry_count == '0 && !busy));

   // R9
   empty_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_count == '0) |-> !hit);

   // R10
   busy_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $rose(busy)) |-> ($past(cmd_valid) && $past(cmd_op) != 2'd3));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && entry_count != $past(entry_count)) |->
         (entry_count == $past(entry_count) + CW'(1) ||
          entry_count == $past(entry_count) - CW'(1) ||
          entry_count == '0));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_valid) |=> $stable(entry_count));
endmodule

bind fetch_watch_unit fw_watch_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_fetch_watch_unit.sv
`timescale 1ns/1ps
module tb_fetch_watch_unit;
   localparam int N  = 8;
   localparam int CW = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [15:0]   cmd_addr = '0;
   logic          busy;
   logic [CW-1:0] entry_count;
   logic [15:0]   fetch_addr = '0;
   logic          hit;

   fetch_watch_unit #(.ENTRIES(N), .ADDR_W(16)) dut (.*);

   always #5 clk = ~clk;

   int n_run  = 0;
   int n_fail = 0;

   typedef struct { int cnt; string req; } exp_t;
   exp_t exp_q[$];
   event done_ev;
   logic [15:0] model[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int find_slot(input logic [15:0] a);
      for (int i = 0; i < model.size(); i++)
         if (model[i] == a) return i;
      return -1;
   endfunction

   // monitor: pops expected counts as commands complete
   initial begin
      forever begin
         @(done_ev);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(entry_count == CW'(e.cnt), e.req, "entry_count", int'(entry_count), e.cnt);
         end
      end
   end

   task automatic probe(input logic [15:0] a, input bit exp, input string req);
      fetch_addr = a;
      #1;
      chk(hit == exp, req, $sformatf("hit @%04h", a), int'(hit), int'(exp));
   endtask

   task automatic probe_all(input string req);
      for (int i = 0; i < model.size(); i++) probe(model[i], 1'b1, req);
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [15:0] a, input string req);
      int k;
      int exp_busy;
      int seen;
      k = find_slot(a);
      exp_busy = (op == 2'd3) ? 0 : ((k >= 0) ? k + 1 : model.size() + 1);
      case (op)
         2'd0: if (k < 0 && model.size() < N) model.push_back(a);
         2'd1: if (k >= 0) begin model[k] = model[model.size()-1]; void'(model.pop_back()); end
         2'd2: if (k >= 0) begin model[k] = model[model.size()-1]; void'(model.pop_back()); end
               else if (model.size() < N) model.push_back(a);
         default: model.delete();
      endcase
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
      @(negedge clk);
      cmd_valid = 1'b0;
      seen = 0;
      while (busy) begin seen++; @(negedge clk); end
      chk(seen == exp_busy, (op == 2'd3) ? "R8" : "R11", "busy cycles", seen, exp_busy);
      exp_q.push_back('{cnt: model.size(), req: req});
      -> done_ev;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int seen;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(entry_count == 0, "R1", "entry_count", int'(entry_count), 0);
      chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
      probe(16'h0000, 1'b0, "R1");
      rst_n = 1'b1;
      @(negedge clk);

      // R2 appends
      run_cmd(2'd0, 16'h1000, "R2");
      run_cmd(2'd0, 16'h2000, "R2");
      run_cmd(2'd0, 16'h3000, "R2");
      probe_all("R2");
      probe(16'h5555, 1'b0, "R9");

      // R4 duplicate add
      run_cmd(2'd0, 16'h2000, "R4");
      probe_all("R4");

      // R6 remove absent
      run_cmd(2'd1, 16'h7777, "R6");
      probe_all("R6");

      // R5 remove slot 0, tail refills it
      run_cmd(2'd1, 16'h1000, "R5");
      probe(16'h1000, 1'b0, "R5");
      probe_all("R5");

      // R7 flip present (tail slot, leaves stale copy) and absent
      run_cmd(2'd2, 16'h2000, "R7");
      probe(16'h2000, 1'b0, "R9");
      run_cmd(2'd2, 16'h4000, "R7");
      probe(16'h4000, 1'b1, "R7");
      probe_all("R7");

      // R10 strobe during search is dropped
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 16'h5000;
      @(negedge clk);
      cmd_op = 2'd0; cmd_addr = 16'h6000;
      @(negedge clk);
      cmd_valid = 1'b0;
      seen = 0;
      while (busy && seen < 50) begin seen++; @(negedge clk); end
      model.push_back(16'h5000);
      exp_q.push_back('{cnt: model.size(), req: "R10"});
      -> done_ev;
      #1;
      probe(16'h5000, 1'b1, "R10");
      probe(16'h6000, 1'b0, "R10");

      // R3 fill then overflow attempts
      for (int i = 0; model.size() < N; i++) run_cmd(2'd0, 16'h0100 + 16'(i), "R2");
      run_cmd(2'd0, 16'hABCD, "R3");
      probe(16'hABCD, 1'b0, "R3");
      run_cmd(2'd2, 16'hBCDE, "R3");
      probe(16'hBCDE, 1'b0, "R3");
      probe_all("R3");

      // R8 wipe, old entries no longer hit (R9)
      run_cmd(2'd3, 16'h0000, "R8");
      probe(16'h3000, 1'b0, "R9");
      probe(16'h5000, 1'b0, "R9");
      run_cmd(2'd0, 16'hBEEF, "R2");
      probe(16'hBEEF, 1'b1, "R2");
      run_cmd(2'd1, 16'hBEEF, "R5");
      probe(16'hBEEF, 1'b0, "R5");

      repeat (2) @(negedge clk);
      -> done_ev;
      #1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule